// File: doc/BRIEF.md
# Cosmic Track Coincidence Trigger

This block forms the final event trigger of a layered tracking detector. It has two orthogonal views, X and Y. Each view has a stack of planes, and every plane delivers four fold-level flags, from 1-fold to 4-fold. For each view the block checks whether the selected M-fold flag is present on N adjacent planes. The view results are ORed into a single final trigger. That final trigger is emitted as a one-cycle pulse, raises an interrupt to the host, increments a scaler, and freezes a snapshot of every fold flag. The host reads the snapshot later.

Software works through a small word-addressed register port. Through it software selects one of four MxN combinations, masks individual fold inputs, masks each view output and the final output, reads and clears the scalers, reads the snapshot, and acknowledges the interrupt. While the interrupt is pending the block stays busy. It emits no new final trigger in that state, so a snapshot can never be overwritten before the host has read it.

Top module: `track_coinc_trig`

## Requirements
- R1: After reset, trig_o and irq_o are 0. All scalers read 0, the control word reads 0 (combination 1x5, no output masked), and all input masks read 0.
- R2: Control bits [1:0] select the combination: 0=1x5, 1=2x4, 2=3x3, 3=4x2. The M-fold flag of plane p sits at fold input bit p*4+(M-1). A view hits when that flag is set on N adjacent planes. N-1 adjacent planes, or a lower fold level, give no hit.
- R3: The final trigger condition is the OR of the two view hits. trig_o pulses high for exactly one cycle, four clock edges after the input change that completes the condition. Both views hitting at the same time give one pulse.
- R4: Input mask bit b of mask word k (X at address 8+k, Y at 12+k) forces fold input k*32+b of that view to 0. A mask write takes effect on the third clock edge after the write.
- R5: Control bit 4 masks the X view output and bit 5 masks the Y view output. Bit 6 masks the final trigger, which then produces no pulse, no interrupt and no scaler count.
- R6: The scalers are X hits (address 1), Y hits (address 2) and final triggers (address 3). The view scalers count rising edges of the view hit, whatever the output mask. A write to a scaler address clears that scaler.
- R7: On each final trigger, all fold inputs are captured: X snapshot words at 16+k, Y snapshot words at 20+k, same bit layout as the masks. They stay unchanged until the next final trigger.
- R8: A final trigger sets irq_o, which reads back at control bit 8. It stays set until a control write with bit 8 set. While it is set, no final trigger is emitted.
- R9: A condition that stays true produces no further trigger. After the interrupt is cleared, a new trigger needs a fresh rising edge of the combined condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_fold_i | input | NPLANE*4 | X view fold flags, asynchronous |
| y_fold_i | input | NPLANE*4 | Y view fold flags, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| trig_o | output | 1 | Final trigger, one-cycle pulse |
| irq_o | output | 1 | Interrupt request, held until cleared |

## Verification
On every cycle the assertions check the following:
- the final trigger is a single-cycle pulse and always arrives together with the interrupt;
- the interrupt holds until it is acknowledged, and no trigger occurs while it was already pending;
- the snapshot moves only on a trigger;
- each scaler steps by exactly one on a count or stays stable;
- fully masked inputs cannot produce a view hit.

Only the bench scenarios can show the rest:
- the run length and fold level needed for each combination;
- exact trigger latency;
- mask bit positions;
- scaler values after mixed view activity;
- snapshot contents;
- the need for a new rising edge after acknowledge.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  localparam int NFOLD = 4;
  localparam int RW    = 32;

  typedef enum logic [1:0] {
    COMBO_1X5 = 2'd0,
    COMBO_2X4 = 2'd1,
    COMBO_3X3 = 2'd2,
    COMBO_4X2 = 2'd3
  } combo_e;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_CNT_X = 1;
  localparam int ADDR_CNT_Y = 2;
  localparam int ADDR_CNT_F = 3;
  localparam int ADDR_XMASK = 8;
  localparam int ADDR_YMASK = 12;
  localparam int ADDR_XSNAP = 16;
  localparam int ADDR_YSNAP = 20;

  // fold level M = sel+1, run length N = NFOLD+1-sel
  function automatic int run_len(combo_e c);
    return NFOLD + 1 - int'(c);
  endfunction
endpackage

// File: rtl/fold_sync.sv
module fold_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/coinc_view.sv
module coinc_view
  import coinc_pkg::*;
#(
  parameter int NPLANE = 14,
  localparam int NIN   = NPLANE * NFOLD
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NIN-1:0] fold_i,
  input  logic [NIN-1:0] mask_i,
  input  combo_e         combo_i,
  output logic           hit_o
);
  logic [NIN-1:0]    act;
  logic [NPLANE-1:0] plane_on;
  logic              hit_d;
  int                need;

  assign act = fold_i & ~mask_i;

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane
    assign plane_on[p] = act[p*NFOLD + int'(combo_i)];
  end

  always_comb begin
    int run;
    need  = run_len(combo_i);
    run   = 0;
    hit_d = 1'b0;
    for (int p = 0; p < NPLANE; p++) begin
      run = plane_on[p] ? run + 1 : 0;
      if (run >= need) hit_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_o <= 1'b0;
    else         hit_o <= hit_d;
  end

  // R4
  all_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(&mask_i) |-> !hit_o);
endmodule

// File: rtl/trig_scaler.sv
module trig_scaler #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    count_o <= '0;
    else if (clr_i) count_o <= '0;
    else if (inc_i) count_o <= count_o + 1'b1;
  end

  // R6
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> (count_o == $past(count_o) + 1'b1));
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(count_o));
endmodule

// File: rtl/track_coinc_trig.sv
module track_coinc_trig
  import coinc_pkg::*;
#(
  parameter int NPLANE = 14,
  parameter int CNT_W  = 32,
  parameter int AW     = 5,
  localparam int NIN   = NPLANE * NFOLD
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NIN-1:0] x_fold_i,
  input  logic [NIN-1:0] y_fold_i,
  input  logic           reg_we_i,
  input  logic [AW-1:0]  reg_addr_i,
  input  logic [RW-1:0]  reg_wdata_i,
  output logic [RW-1:0]  reg_rdata_o,
  output logic           trig_o,
  output logic           irq_o
);
  localparam int NWORD = (NIN + RW - 1) / RW;

  logic [NIN-1:0] xs, ys, xd_q, yd_q;
  logic [NIN-1:0] xmask_q, ymask_q, xsnap_q, ysnap_q;
  combo_e         combo_q;
  logic [2:0]     omask_q;
  logic           x_hit, y_hit, x_prev_q, y_prev_q;
  logic           cond, cond_prev_q, fire, irq_q, trig_q;
  logic           wr_ctrl, irq_clr;
  logic [CNT_W-1:0] cnt [3];
  logic [2:0]     cnt_inc, cnt_clr;

  fold_sync #(.W(NIN)) u_sync_x (.clk_i, .rst_ni, .d_i(x_fold_i), .q_o(xs));
  fold_sync #(.W(NIN)) u_sync_y (.clk_i, .rst_ni, .d_i(y_fold_i), .q_o(ys));

  coinc_view #(.NPLANE(NPLANE)) u_view_x (
    .clk_i, .rst_ni, .fold_i(xs), .mask_i(xmask_q), .combo_i(combo_q), .hit_o(x_hit));
  coinc_view #(.NPLANE(NPLANE)) u_view_y (
    .clk_i, .rst_ni, .fold_i(ys), .mask_i(ymask_q), .combo_i(combo_q), .hit_o(y_hit));

  assign wr_ctrl = reg_we_i && (reg_addr_i == AW'(ADDR_CTRL));
  assign irq_clr = wr_ctrl && reg_wdata_i[8];

  assign cond = (x_hit & ~omask_q[0]) | (y_hit & ~omask_q[1]);
  assign fire = cond & ~cond_prev_q & ~omask_q[2] & ~irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      combo_q     <= COMBO_1X5;
      omask_q     <= '0;
      xd_q        <= '0;
      yd_q        <= '0;
      x_prev_q    <= 1'b0;
      y_prev_q    <= 1'b0;
      cond_prev_q <= 1'b0;
      trig_q      <= 1'b0;
      irq_q       <= 1'b0;
      xsnap_q     <= '0;
      ysnap_q     <= '0;
    end else begin
      xd_q        <= xs;
      yd_q        <= ys;
      x_prev_q    <= x_hit;
      y_prev_q    <= y_hit;
      cond_prev_q <= cond;
      trig_q      <= fire;
      if (wr_ctrl) begin
        combo_q <= combo_e'(reg_wdata_i[1:0]);
        omask_q <= reg_wdata_i[6:4];
      end
      if (fire) begin
        irq_q   <= 1'b1;
        xsnap_q <= xd_q;
        ysnap_q <= yd_q;
      end else if (irq_clr) begin
        irq_q <= 1'b0;
      end
    end
  end

  // input masks, bit b lives in word b/RW at position b%RW
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xmask_q <= '0;
      ymask_q <= '0;
    end else if (reg_we_i) begin
      for (int b = 0; b < NIN; b++) begin
        if (reg_addr_i == AW'(ADDR_XMASK + b / RW)) xmask_q[b] <= reg_wdata_i[b % RW];
        if (reg_addr_i == AW'(ADDR_YMASK + b / RW)) ymask_q[b] <= reg_wdata_i[b % RW];
      end
    end
  end

  assign cnt_inc = {fire, y_hit & ~y_prev_q, x_hit & ~x_prev_q};

  for (genvar i = 0; i < 3; i++) begin : g_cnt
    assign cnt_clr[i] = reg_we_i && (reg_addr_i == AW'(ADDR_CNT_X + i));
    trig_scaler #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .inc_i(cnt_inc[i]), .clr_i(cnt_clr[i]), .count_o(cnt[i]));
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == AW'(ADDR_CTRL)) begin
      reg_rdata_o[1:0] = combo_q;
      reg_rdata_o[6:4] = omask_q;
      reg_rdata_o[8]   = irq_q;
    end
    for (int i = 0; i < 3; i++)
      if (reg_addr_i == AW'(ADDR_CNT_X + i)) reg_rdata_o[CNT_W-1:0] = cnt[i];
    for (int b = 0; b < NIN; b++) begin
      if (reg_addr_i == AW'(ADDR_XMASK + b / RW)) reg_rdata_o[b % RW] = xmask_q[b];
      if (reg_addr_i == AW'(ADDR_YMASK + b / RW)) reg_rdata_o[b % RW] = ymask_q[b];
      if (reg_addr_i == AW'(ADDR_XSNAP + b / RW)) reg_rdata_o[b % RW] = xsnap_q[b];
      if (reg_addr_i == AW'(ADDR_YSNAP + b / RW)) reg_rdata_o[b % RW] = ysnap_q[b];
    end
  end

  assign trig_o = trig_q;
  assign irq_o  = irq_q;

  initial begin
    if (NWORD > 4) $error("NPLANE too large for the register map");
  end

  // R3
  trig_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
  // R8
  irq_with_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> irq_o);
  // R8
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(irq_o)) |-> !trig_o);
  // R8
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(reg_we_i && reg_addr_i == AW'(ADDR_CTRL) && reg_wdata_i[8])) |=> irq_o);
  // R7
  snap_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_o |-> $stable({xsnap_q, ysnap_q}));
endmodule

// File: tb/track_coinc_trig_tb.sv
module track_coinc_trig_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPLANE = 14;
  localparam int NIN = NPLANE * 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NIN-1:0] xf = '0, yf = '0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic trig, irq;

  int cyc = 0, last_cyc = 0, checks = 0, errors = 0;
  int exp_q[$];
  bit done = 1'b0;

  track_coinc_trig u_dut (
    .clk_i(clk), .rst_ni(rst_n), .x_fold_i(xf), .y_fold_i(yf),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .trig_o(trig), .irq_o(irq));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [NIN-1:0] run_vec(int first, int last, int m);
    logic [NIN-1:0] v = '0;
    for (int p = first; p <= last; p++) v[p*4 + m - 1] = 1'b1;
    return v;
  endfunction

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d; last_cyc = cyc;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(int a, logic [31:0] exp, string req, string what);
    @(negedge clk);
    reg_addr = 5'(a);
    #1;
    check(req, what, reg_rdata, exp);
  endtask

  task automatic drive(logic [NIN-1:0] xv, logic [NIN-1:0] yv);
    @(negedge clk);
    xf = xv; yf = yv; last_cyc = cyc;
  endtask

  // scoreboard push: expected trigger cycle
  task automatic expect_trig(int lat);
    exp_q.push_back(last_cyc + lat);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (trig) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R3 unexpected trigger at cycle %0d: actual 1 expected 0", cyc);
        end else begin
          check("R3", "trigger cycle", 32'(cyc), 32'(exp_q.pop_front()));
        end
      end else if (exp_q.size() > 0 && cyc > exp_q[0]) begin
        checks++; errors++;
        $display("FAIL R3 missing trigger: actual none expected cycle %0d", exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1", "trig in reset", 32'(trig), 0);
    check("R1", "irq in reset", 32'(irq), 0);
    @(negedge clk); rst_n = 1'b1;
    rd_chk(0, 0, "R1", "ctrl");
    rd_chk(1, 0, "R1", "x count");
    rd_chk(2, 0, "R1", "y count");
    rd_chk(3, 0, "R1", "final count");
    rd_chk(8, 0, "R1", "x mask0");
    rd_chk(13, 0, "R1", "y mask1");

    // R2: 1x5, four planes only
    drive(run_vec(2, 5, 1), '0); idle(8);
    rd_chk(1, 0, "R2", "x count short run");
    drive(run_vec(2, 6, 1), '0); expect_trig(4); idle(8);
    check("R8", "irq after trigger", 32'(irq), 1);
    rd_chk(0, 32'h100, "R8", "ctrl irq bit");
    rd_chk(3, 1, "R6", "final count");
    rd_chk(1, 1, "R6", "x count");
    rd_chk(2, 0, "R6", "y count");
    rd_chk(16, 32'h0111_1100, "R7", "x snap0");
    rd_chk(17, 0, "R7", "x snap1");

    // R9: clear irq with condition held
    wr(0, 32'h100); idle(8);
    rd_chk(0, 0, "R9", "irq cleared");
    drive('0, '0); idle(8);
    drive(run_vec(2, 6, 1), '0); expect_trig(4); idle(8);
    rd_chk(3, 2, "R9", "final count after new edge");
    wr(0, 32'h100); drive('0, '0); idle(8);

    // R2: 4x2 on the top planes of Y
    wr(0, 32'h3);
    drive('0, run_vec(12, 13, 3)); idle(8);
    rd_chk(2, 0, "R2", "y count lower fold");
    drive('0, run_vec(12, 13, 3) | run_vec(12, 13, 4)); expect_trig(4); idle(8);
    rd_chk(21, 32'h00CC_0000, "R7", "y snap1");
    rd_chk(2, 1, "R6", "y count");
    wr(0, 32'h103); drive('0, '0); idle(8);

    // R4: 3x3 with one input masked
    wr(0, 32'h2);
    wr(8, 32'h40);
    rd_chk(8, 32'h40, "R4", "x mask readback");
    drive(run_vec(0, 2, 3), '0); idle(8);
    check("R4", "irq while masked", 32'(irq), 0);
    wr(8, 32'h0); expect_trig(3); idle(8);
    rd_chk(1, 3, "R4", "x count after unmask");
    wr(0, 32'h102); drive('0, '0); idle(8);

    // R5: X output masked, Y still triggers
    wr(0, 32'h12);
    drive(run_vec(5, 7, 3), '0); idle(8);
    check("R5", "irq with x masked", 32'(irq), 0);
    rd_chk(1, 4, "R6", "x count ignores output mask");
    drive(run_vec(5, 7, 3), run_vec(0, 2, 3)); expect_trig(4); idle(8);
    rd_chk(3, 5, "R5", "final count via y");
    wr(0, 32'h112); drive('0, '0); idle(8);

    // R5: final output masked
    wr(0, 32'h42);
    drive(run_vec(3, 5, 3), run_vec(3, 5, 3)); idle(8);
    check("R5", "irq with final masked", 32'(irq), 0);
    rd_chk(3, 5, "R5", "final count masked");
    drive('0, '0); idle(8);

    // R3: both views at once give one pulse
    wr(0, 32'h2);
    drive(run_vec(3, 5, 3), run_vec(3, 5, 3)); expect_trig(4); idle(8);
    rd_chk(3, 6, "R3", "final count both views");
    rd_chk(1, 6, "R6", "x count");
    rd_chk(2, 4, "R6", "y count");

    // R8: busy while irq pending
    drive('0, '0); idle(8);
    drive(run_vec(8, 10, 3), '0); idle(8);
    rd_chk(3, 6, "R8", "final count while busy");
    rd_chk(16, 32'h0044_4000, "R8", "x snap kept while busy");
    rd_chk(20, 32'h0044_4000, "R7", "y snap0");
    wr(0, 32'h102); idle(8);
    rd_chk(0, 32'h2, "R9", "no retrigger after clear");

    // R6: scaler clear
    wr(3, 32'h0);
    rd_chk(3, 0, "R6", "final count cleared");
    rd_chk(1, 7, "R6", "x count kept");

    drive('0, '0); idle(8);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3 pending triggers: actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule